// File: doc/BRIEF.md
# Signed and Unsigned Long-by-Word Divider

This block divides a double-width dividend by a single-width divisor. It runs as a multi-cycle restoring shift-subtract engine. A mode input picks unsigned or two's-complement division for each operation. In signed mode the divisor is treated as sign-extended. The loop always works on magnitudes, and the block corrects the signs of the quotient and remainder after the loop. The remainder goes in the upper half of a packed result word and the quotient in the lower half.

The caller also supplies its current condition flags. The block returns updated flags packed as {N, Z, V, C} in bits 3..0. When the divisor is zero, the block raises a one-cycle exception strobe. When the quotient does not fit the result half, the block reports overflow in V. In both of these cases the returned word is the dividend, so the destination keeps its old value. While an operation is in progress, a new start request is dropped.

Top module: `wdiv_unit`

## Requirements
- R1: In unsigned mode (signed_mode=0), with a nonzero divisor and a quotient below 2^QW, result is {remainder, quotient}: the remainder in bits [2QW-1:QW] and the quotient in bits [QW-1:0].
- R2: In signed mode (signed_mode=1), both operands are two's complement. The quotient is truncated toward zero, the remainder takes the sign of the dividend, and both are packed as in R1.
- R3: On a successful division, flags_out[1] (V) is 0, flags_out[3] (N) equals quotient bit QW-1, and flags_out[2] (Z) is 1 exactly when the QW-bit quotient is zero.
- R4: If the quotient does not fit in QW bits, the operation ends with overflow. The limits are [-2^(QW-1), 2^(QW-1)-1] in signed mode and [0, 2^QW-1] in unsigned mode. On overflow, result equals the dividend, V is 1, and N and Z are copied from flags_in[3] and flags_in[2].
- R5: A zero divisor pulses div_zero together with done, one cycle after start is sampled. In that case result equals the dividend and flags_out is 4'b0000.
- R6: flags_out[0] (C) is 0 after every operation.
- R7: done is high for exactly one cycle. For a nonzero divisor, done appears 2QW+1 rising edges after the edge that samples start.
- R8: A start raised while an operation is in progress is ignored: no second done follows, and the result belongs to the first request.
- R9: While reset is asserted, done, div_zero, result and flags_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; sampled only when idle |
| signed_mode | input | 1 | 1 = two's-complement division, 0 = unsigned division |
| dividend | input | 2*QW | Dividend; also the prior destination value |
| divisor | input | QW | Divisor |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2*QW | Packed {remainder, quotient}, or the dividend if the division failed |
| flags_out | output | 4 | Updated flags {N,Z,V,C} |
| div_zero | output | 1 | One-cycle divide-by-zero exception strobe |

## Verification
The assertions assume that reset is applied before the first request. They also assume that start may arrive at any time, including while the loop is running. In the busy state, the assertions rely only on the captured copy of the dividend, never on the live input pins, so the stimulus is free to change operands while the loop runs. The bench sweeps every dividend, divisor and mode of a 4-bit-quotient configuration. In that configuration the overflow, zero-divisor and most-negative operand cases all occur. It also rotates the incoming flags so that the preserved N and Z values are visible.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } wdiv_state_e;

    // Flag positions in the packed flag nibble.
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
    localparam int FLG_W = 4;
endpackage

// File: rtl/wdiv_mag.sv
module wdiv_mag #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         sgn_en,
    output logic [W-1:0] mag,
    output logic         neg
);
    always_comb begin
        neg = sgn_en & val[W-1];
        mag = neg ? (~val + W'(1)) : val;
    end
endmodule

// File: rtl/wdiv_step.sv
module wdiv_step #(
    parameter int QW = 16,
    parameter int DW = 2 * QW
) (
    input  logic [QW-1:0] part,
    input  logic [DW-1:0] quo,
    input  logic [QW-1:0] dvs,
    output logic [QW-1:0] part_nx,
    output logic [DW-1:0] quo_nx
);
    logic [QW:0] shifted;
    logic [QW:0] diff;
    logic        ge;

    always_comb begin
        shifted = {part, quo[DW-1]};
        diff    = shifted - {1'b0, dvs};
        ge      = (shifted >= {1'b0, dvs});
        part_nx = ge ? diff[QW-1:0] : shifted[QW-1:0];
        quo_nx  = {quo[DW-2:0], ge};
    end
endmodule

// File: rtl/wdiv_post.sv
module wdiv_post
    import wdiv_pkg::*;
#(
    parameter int QW = 16,
    parameter int DW = 2 * QW
) (
    input  logic [DW-1:0]    quo_mag,
    input  logic [QW-1:0]    rem_mag,
    input  logic             neg_q,
    input  logic             neg_r,
    input  logic             sgn,
    input  logic [DW-1:0]    dvd,
    input  logic [FLG_W-1:0] fin,
    output logic [DW-1:0]    res,
    output logic [FLG_W-1:0] flg
);
    logic [DW-1:0] lim;
    logic          ovf;
    logic [QW-1:0] q_fix;
    logic [QW-1:0] r_fix;

    always_comb begin
        // Largest magnitude the signed quotient may have, by its sign.
        lim = (DW'(1) << (QW - 1)) - DW'(!neg_q);
        if (sgn) begin
            ovf = (quo_mag > lim);
        end else begin
            ovf = |quo_mag[DW-1:QW];
        end
        q_fix = neg_q ? (~quo_mag[QW-1:0] + QW'(1)) : quo_mag[QW-1:0];
        r_fix = neg_r ? (~rem_mag + QW'(1)) : rem_mag;

        flg = '0;
        if (ovf) begin
            res        = dvd;
            flg[FLG_N] = fin[FLG_N];
            flg[FLG_Z] = fin[FLG_Z];
            flg[FLG_V] = 1'b1;
        end else begin
            res        = {r_fix, q_fix};
            flg[FLG_N] = q_fix[QW-1];
            flg[FLG_Z] = (q_fix == '0);
        end
        flg[FLG_C] = 1'b0;
    end
endmodule

// File: rtl/wdiv_unit.sv
module wdiv_unit
    import wdiv_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              signed_mode,
    input  logic [2*QW-1:0]   dividend,
    input  logic [QW-1:0]     divisor,
    input  logic [FLG_W-1:0]  flags_in,
    output logic              done,
    output logic [2*QW-1:0]   result,
    output logic [FLG_W-1:0]  flags_out,
    output logic              div_zero
);
    localparam int DW = 2 * QW;
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        wdiv_state_e      st;
        logic [CW-1:0]    cnt;
        logic [QW-1:0]    part;
        logic [DW-1:0]    quo;
        logic [QW-1:0]    dvs;
        logic             neg_q;
        logic             neg_r;
        logic             sgn;
        logic [DW-1:0]    dvd;
        logic [FLG_W-1:0] fin;
        logic             done;
        logic             dz;
        logic [DW-1:0]    res;
        logic [FLG_W-1:0] flg;
    } regs_t;

    regs_t r_d, r_q;

    logic [DW-1:0]    dvd_mag;
    logic             dvd_neg;
    logic [QW-1:0]    dvs_mag;
    logic             dvs_neg;
    logic [QW-1:0]    part_nx;
    logic [DW-1:0]    quo_nx;
    logic [DW-1:0]    post_res;
    logic [FLG_W-1:0] post_flg;

    wdiv_mag #(.W(DW)) u_mag_dvd (
        .val(dividend), .sgn_en(signed_mode), .mag(dvd_mag), .neg(dvd_neg)
    );
    wdiv_mag #(.W(QW)) u_mag_dvs (
        .val(divisor), .sgn_en(signed_mode), .mag(dvs_mag), .neg(dvs_neg)
    );

    wdiv_step #(.QW(QW), .DW(DW)) u_step (
        .part(r_q.part), .quo(r_q.quo), .dvs(r_q.dvs),
        .part_nx(part_nx), .quo_nx(quo_nx)
    );

    wdiv_post #(.QW(QW), .DW(DW)) u_post (
        .quo_mag(r_q.quo), .rem_mag(r_q.part), .neg_q(r_q.neg_q),
        .neg_r(r_q.neg_r), .sgn(r_q.sgn), .dvd(r_q.dvd), .fin(r_q.fin),
        .res(post_res), .flg(post_flg)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.dz   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.dvd = dividend;
                    r_d.fin = flags_in;
                    r_d.sgn = signed_mode;
                    if (divisor == '0) begin
                        r_d.done = 1'b1;
                        r_d.dz   = 1'b1;
                        r_d.res  = dividend;
                        r_d.flg  = '0;
                    end else begin
                        r_d.st    = ST_RUN;
                        r_d.cnt   = '0;
                        r_d.part  = '0;
                        r_d.quo   = dvd_mag;
                        r_d.dvs   = dvs_mag;
                        r_d.neg_q = dvd_neg ^ dvs_neg;
                        r_d.neg_r = dvd_neg;
                    end
                end
            end
            ST_RUN: begin
                r_d.part = part_nx;
                r_d.quo  = quo_nx;
                r_d.cnt  = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(DW - 1)) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.done = 1'b1;
                r_d.res  = post_res;
                r_d.flg  = post_flg;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign div_zero  = r_q.dz;
    assign result    = r_q.res;
    assign flags_out = r_q.flg;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (done && flags_out == '0)); // R5
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flags_out[FLG_C]); // R6
    AST_FAIL_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (div_zero || flags_out[FLG_V])) |-> (result == r_q.dvd)); // R4
    AST_NZ_FOLLOW_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !flags_out[FLG_V]) |->
        (flags_out[FLG_N] == result[QW-1] &&
         flags_out[FLG_Z] == (result[QW-1:0] == '0))); // R3
    AST_BUSY_HOLDS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> $stable(r_q.dvd)); // R8
endmodule

// File: tb/tb_wdiv_unit.sv
`timescale 1ns/1ps
module tb_wdiv_unit;
    localparam int QW = 4;
    localparam int DW = 2 * QW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          signed_mode;
    logic [DW-1:0] dividend;
    logic [QW-1:0] divisor;
    logic [3:0]    flags_in;
    logic          done;
    logic [DW-1:0] result;
    logic [3:0]    flags_out;
    logic          div_zero;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wdiv_unit #(.QW(QW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .flags_in(flags_in),
        .done(done), .result(result), .flags_out(flags_out), .div_zero(div_zero)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference computation from the requirements.
    task automatic model(input logic sm, input logic [DW-1:0] a, input logic [QW-1:0] b,
                         input logic [3:0] fi, output logic [DW-1:0] res,
                         output logic [3:0] fl, output logic dz, output logic ovf);
        int ai;
        int bi;
        int q;
        int r;
        logic [31:0] qv;
        logic [31:0] rv;
        ai = int'(a);
        bi = int'(b);
        if (sm && a[DW-1]) ai = ai - (1 << DW);
        if (sm && b[QW-1]) bi = bi - (1 << QW);
        dz = 1'b0;
        ovf = 1'b0;
        if (bi == 0) begin
            dz  = 1'b1;
            res = a;
            fl  = 4'b0000;
        end else begin
            q = ai / bi;
            r = ai % bi;
            if (sm) ovf = (q > (1 << (QW - 1)) - 1) || (q < -(1 << (QW - 1)));
            else    ovf = (q > (1 << QW) - 1);
            if (ovf) begin
                res = a;
                fl  = {fi[3], fi[2], 2'b10};
            end else begin
                qv  = q;
                rv  = r;
                res = {rv[QW-1:0], qv[QW-1:0]};
                fl  = {qv[QW-1], (qv[QW-1:0] == '0), 2'b00};
            end
        end
    endtask

    task automatic run_op(input logic sm, input logic [DW-1:0] a, input logic [QW-1:0] b,
                          input logic [3:0] fi, output int lat, output logic [DW-1:0] res,
                          output logic [3:0] fl, output logic dzs, output bit pulse_ok);
        @(negedge clk);
        signed_mode = sm;
        dividend    = a;
        divisor     = b;
        flags_in    = fi;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res = result;
        fl  = flags_out;
        dzs = div_zero;
        @(negedge clk);
        pulse_ok = !done && !div_zero;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [DW-1:0] res, eres;
        logic [3:0] fl, efl;
        logic dzs, edz, eovf;
        bit pulse_ok;
        int extra;

        rst_n = 1'b0;
        start = 1'b0;
        signed_mode = 1'b0;
        dividend = '0;
        divisor = '0;
        flags_in = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(done == 0 && div_zero == 0, "R9", "strobes in reset", {done, div_zero}, 0);
        chk(result == 0, "R9", "result in reset", result, 0);
        chk(flags_out == 0, "R9", "flags in reset", flags_out, 0);
        rst_n = 1'b1;

        // Full sweep of mode, dividend and divisor.
        for (int sm = 0; sm < 2; sm++) begin
            for (int a = 0; a < (1 << DW); a++) begin
                for (int b = 0; b < (1 << QW); b++) begin
                    logic [3:0] fi;
                    string rq;
                    fi = 4'((a + b * 3 + sm) & 15);
                    model(sm[0], DW'(a), QW'(b), fi, eres, efl, edz, eovf);
                    run_op(sm[0], DW'(a), QW'(b), fi, lat, res, fl, dzs, pulse_ok);
                    if (edz)       rq = "R5";
                    else if (eovf) rq = "R4";
                    else if (sm)   rq = "R2";
                    else           rq = "R1";
                    chk(res == eres, rq, "result", res, eres);
                    chk(dzs == edz, "R5", "div_zero strobe", dzs, edz);
                    chk(fl[1] == efl[1] && fl[3:2] == efl[3:2],
                        (edz || eovf) ? rq : "R3", "flags N Z V", fl, efl);
                    chk(fl[0] == 1'b0, "R6", "carry flag", fl, 0);
                    chk(lat == (edz ? 1 : DW + 2), "R7", "latency", lat, edz ? 1 : DW + 2);
                    chk(pulse_ok, "R7", "strobe width", {done, div_zero}, 0);
                end
            end
        end

        // R8: start while busy is dropped.
        @(negedge clk);
        signed_mode = 1'b0;
        dividend = 8'd100;
        divisor = 4'd7;
        flags_in = 4'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        dividend = 8'hFF;
        divisor = 4'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(result == 8'h2E, "R8", "result of first request", result, 8'h2E);
        extra = 0;
        repeat (DW + 6) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R8", "extra done pulses", extra, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule